// File: doc/BRIEF.md
# Processor Bus Slave Responder

This block is a memory-mapped target on a 32-bit processor system bus. The master places an address, a read/write direction, a two-bit transfer size and a three-bit transfer code on the bus. It then asserts an active-low request strobe while also holding an active-low busy strobe. At that clock edge the responder captures the access and counts a fixed number of wait cycles. It then ends the access with a one-clock active-low acknowledge, or with a one-clock active-low error acknowledge when the access cannot be served.

Storage is a small array of 32-bit words placed at a configurable base address. Byte, halfword and word accesses are served on big-endian byte lanes, and a partial write changes only the lanes it addresses. An active-low abort from the master cancels the access in progress: no termination is issued and no write is committed. The transfer code is captured with the request but does not change the response.

Top module: `bus_slave_resp`

## Requirements
- R1: After reset, `ta_n` and `tea_n` are high, `rdata` is zero and every storage byte reads as zero.
- R2: An access is taken at a rising edge where `treq_n` and `tbusy_n` are both low and `abort_n` is high. A low `treq_n` while `tbusy_n` is high is ignored: there is no termination and no write.
- R3: For an access taken at edge E0, the termination strobe is low for exactly the one cycle that follows rising edge E0+WAIT_CYCLES+1, with WAIT_CYCLES from 0 to 3.
- R4: `ta_n` and `tea_n` are never low in the same cycle, and a served access produces exactly one of them.
- R5: Size code 00 selects a word access. A word written at an aligned in-range address reads back unchanged on all 32 bits.
- R6: Size code 01 selects a byte access. Byte offset k (address bits 1:0) uses data bits [31-8k:24-8k]. A byte read returns that lane and zeros elsewhere.
- R7: A byte write updates only its lane of the addressed word, whatever the master drives on the other lanes.
- R8: Size code 10 selects a halfword access. Offset 0 uses bits 31:16 and offset 2 uses bits 15:0. Only those lanes are written or returned.
- R9: Size code 11 is reserved. It is answered with `tea_n` and writes nothing.
- R10: A halfword access with address bit 0 set, or a word access with address bits 1:0 not 00, is answered with `tea_n` and writes nothing.
- R11: An address below BASE_ADDR, or at or above BASE_ADDR+4*DEPTH, is answered with `tea_n`.
- R12: A low `abort_n` at a rising edge gives high `ta_n` and `tea_n` in the following cycle. An aborted access is never terminated and its write is not committed.
- R13: `rdata` is zero in every cycle except the acknowledge cycle of a successful read.
- R14: With `tbusy_n` held low, a new request presented in the cycle of a termination is taken at the next edge and served with the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 32 | Byte address of the access |
| rw | input | 1 | 1 = read, 0 = write |
| tsiz | input | 2 | Transfer size: 00 word, 01 byte, 10 halfword, 11 reserved |
| tcode | input | 3 | Transfer code, captured but not acted on |
| treq_n | input | 1 | Active-low new-access request |
| tbusy_n | input | 1 | Active-low access-in-progress strobe |
| wdata | input | 32 | Write data from the master |
| abort_n | input | 1 | Active-low immediate cancel of the current access |
| rdata | output | 32 | Read data, valid only during a read acknowledge |
| ta_n | output | 1 | Active-low one-cycle transfer acknowledge |
| tea_n | output | 1 | Active-low one-cycle error acknowledge |

## Verification
The bench targets lane placement first. It writes a known word and then reads individual bytes and halfwords at each offset. A design with a swapped lane order would return the value shifted to the wrong bits, and a design that ignored the size on writes would overwrite neighbouring lanes with the junk the bench drives there. The error paths are each followed by a full-word read. This exposes a design that flags the error but still commits the write, and the same check applies after an abort issued during the wait window. Every access is watched for the exact termination cycle and for a single pulse. The bench also sends a request without the busy strobe and a back-to-back request in the acknowledge cycle, which catch a design that is off by one wait cycle, stretches its strobes, accepts unqualified requests or drops the second transfer.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
// Package: shared types and lane helpers for the bus slave responder.
// Assumes a 32-bit data bus split into four byte lanes, big-endian order.
package bsr_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } state_e;

    // Lane enables: bit 3 = data bits 31:24 (byte offset 0), bit 0 = bits 7:0.
    function automatic logic [LANES-1:0] lane_mask(size_e sz, logic [1:0] off);
        logic [LANES-1:0] m;
        case (sz)
            SZ_BYTE: m = 4'b1000 >> off;
            SZ_HALF: m = off[1] ? 4'b0011 : 4'b1100;
            SZ_WORD: m = 4'b1111;
            default: m = 4'b0000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bsr_decode.sv
`timescale 1ns/1ps
// Module: bsr_decode
// Turns a captured address and size into a word index, lane enables and a
// fault flag (reserved size, misalignment or out-of-range address).
// Assumes DEPTH >= 2 and that BASE_ADDR is word aligned. Purely combinational.
module bsr_decode
    import bsr_pkg::*;
#(
    parameter int          DEPTH     = 16,
    parameter logic [31:0] BASE_ADDR = 32'h0000_4000,
    localparam int         IDX_W     = $clog2(DEPTH)
) (
    input  logic [31:0]      addr,
    input  size_e            size,
    output logic [IDX_W-1:0] idx,
    output logic [LANES-1:0] lanes,
    output logic             fault
);

    localparam logic [31:0] SPAN = 32'(DEPTH * 4);

    logic [31:0] off;
    logic        in_range;
    logic        misaligned;

    // Offset from base and range test.
    always_comb begin
        off      = addr - BASE_ADDR;
        in_range = (addr >= BASE_ADDR) && (off < SPAN);
        idx      = off[IDX_W+1:2];
    end

    // Alignment and size legality, then lane enables.
    always_comb begin
        misaligned = ((size == SZ_HALF) && addr[0]) ||
                     ((size == SZ_WORD) && (addr[1:0] != 2'b00));
        fault      = !in_range || misaligned || (size == SZ_RSVD);
        lanes      = fault ? '0 : lane_mask(size, addr[1:0]);
    end

endmodule

// File: rtl/bsr_store.sv
`timescale 1ns/1ps
// Module: bsr_store
// Word array built as one byte-wide bank per lane, so a partial write touches
// only the enabled banks. Read is combinational from the indexed word.
// Assumes the write enable already excludes faulted and aborted accesses.
module bsr_store
    import bsr_pkg::*;
#(
    parameter int  DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [LANES-1:0] lanes,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rword
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] bank [DEPTH];

        // Clear on reset, else write this lane when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) bank[i] <= 8'h00;
            end else if (we && lanes[g]) begin
                bank[idx] <= wdata[8*g +: 8];
            end
        end

        assign rword[8*g +: 8] = bank[idx];
    end

endmodule

// File: rtl/bsr_ctrl.sv
`timescale 1ns/1ps
// Module: bsr_ctrl
// Access sequencer: captures a qualified request, counts WAIT_CYCLES, then
// issues exactly one registered termination (acknowledge or error) unless an
// abort arrives first. Drives the write enable and the lane-masked read data.
// Assumes WAIT_CYCLES is between 0 and 3.
module bsr_ctrl
    import bsr_pkg::*;
#(
    parameter int WAIT_CYCLES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             treq_n,
    input  logic             tbusy_n,
    input  logic             abort_n,
    input  logic [31:0]      addr,
    input  logic             rw,
    input  logic [1:0]       tsiz,
    input  logic             fault,
    input  logic [LANES-1:0] lanes,
    input  logic [31:0]      rword,
    output logic [31:0]      req_addr,
    output size_e            req_size,
    output logic             we,
    output logic [31:0]      rdata,
    output logic             ta_n,
    output logic             tea_n
);

    state_e      state;
    logic [1:0]  cnt;
    logic        rd_q;
    logic        ending;
    logic [31:0] masked;

    // Final cycle of a live access: wait count spent and no abort.
    assign ending = (state == ST_WAIT) && abort_n && (cnt == 2'd0);
    assign we     = ending && !fault && !rd_q;

    // Keep only the addressed lanes of the stored word.
    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign masked[8*g +: 8] = lanes[g] ? rword[8*g +: 8] : 8'h00;
    end

    // Request capture, wait counting, abort and termination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= 2'd0;
            rd_q     <= 1'b1;
            req_addr <= '0;
            req_size <= SZ_WORD;
            ta_n     <= 1'b1;
            tea_n    <= 1'b1;
            rdata    <= '0;
        end else begin
            ta_n  <= 1'b1;
            tea_n <= 1'b1;
            rdata <= '0;
            case (state)
                ST_IDLE: begin
                    if (!treq_n && !tbusy_n && abort_n) begin
                        req_addr <= addr;
                        req_size <= size_e'(tsiz);
                        rd_q     <= rw;
                        cnt      <= 2'(WAIT_CYCLES);
                        state    <= ST_WAIT;
                    end
                end
                default: begin
                    if (!abort_n) begin
                        state <= ST_IDLE;
                    end else if (cnt == 2'd0) begin
                        state <= ST_IDLE;
                        if (fault) begin
                            tea_n <= 1'b0;
                        end else begin
                            ta_n <= 1'b0;
                            if (rd_q) rdata <= masked;
                        end
                    end else begin
                        cnt <= cnt - 2'd1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/bus_slave_resp.sv
`timescale 1ns/1ps
// Module: bus_slave_resp (top)
// Memory-mapped slave on a 32-bit processor bus with active-low request,
// busy, acknowledge, error and abort strobes. Serves byte, halfword and word
// accesses to DEPTH words at BASE_ADDR, big-endian lanes.
// Assumes a single master and WAIT_CYCLES in 0..3. The transfer code is
// accepted but does not influence the response.
module bus_slave_resp
    import bsr_pkg::*;
#(
    parameter int          DEPTH       = 16,
    parameter logic [31:0] BASE_ADDR   = 32'h0000_4000,
    parameter int          WAIT_CYCLES = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] addr,
    input  logic        rw,
    input  logic [1:0]  tsiz,
    input  logic [2:0]  tcode,
    input  logic        treq_n,
    input  logic        tbusy_n,
    input  logic [31:0] wdata,
    input  logic        abort_n,
    output logic [31:0] rdata,
    output logic        ta_n,
    output logic        tea_n
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [31:0]      req_addr;
    size_e            req_size;
    logic [IDX_W-1:0] idx;
    logic [LANES-1:0] lanes;
    logic             fault;
    logic             we;
    logic [31:0]      rword;
    logic             unused_tcode;

    // The transfer code has no effect on this target.
    assign unused_tcode = ^tcode;

    bsr_ctrl #(.WAIT_CYCLES(WAIT_CYCLES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .treq_n   (treq_n),
        .tbusy_n  (tbusy_n),
        .abort_n  (abort_n),
        .addr     (addr),
        .rw       (rw),
        .tsiz     (tsiz),
        .fault    (fault),
        .lanes    (lanes),
        .rword    (rword),
        .req_addr (req_addr),
        .req_size (req_size),
        .we       (we),
        .rdata    (rdata),
        .ta_n     (ta_n),
        .tea_n    (tea_n)
    );

    bsr_decode #(.DEPTH(DEPTH), .BASE_ADDR(BASE_ADDR)) u_decode (
        .addr  (req_addr),
        .size  (req_size),
        .idx   (idx),
        .lanes (lanes),
        .fault (fault)
    );

    bsr_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .lanes (lanes),
        .idx   (idx),
        .wdata (wdata),
        .rword (rword)
    );

endmodule

// File: rtl/bsr_checker.sv
`timescale 1ns/1ps
// Module: bsr_checker
// Port-level protocol properties of bus_slave_resp, attached with bind.
module bsr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        abort_n,
    input logic        ta_n,
    input logic        tea_n,
    input logic [31:0] rdata
);

    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ta_n && !tea_n)); // R4

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ta_n || !tea_n) |=> (ta_n && tea_n)); // R3

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ta_n |-> (rdata == 32'h0)); // R13

    AST_ABORT_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_n |=> (ta_n && tea_n)); // R12

endmodule

bind bus_slave_resp bsr_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort_n (abort_n),
    .ta_n    (ta_n),
    .tea_n   (tea_n),
    .rdata   (rdata)
);

// File: tb/tb_bus_slave_resp.sv
`timescale 1ns/1ps
// Directed bench for bus_slave_resp: one task per scenario.
module tb_bus_slave_resp;

    localparam int          DEPTH = 16;
    localparam logic [31:0] BASE  = 32'h0000_4000;
    localparam int          WAITC = 1;
    localparam int          LAT   = WAITC + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        rw = 1'b1;
    logic [1:0]  tsiz = 2'b00;
    logic [2:0]  tcode = 3'b000;
    logic        treq_n = 1'b1;
    logic        tbusy_n = 1'b1;
    logic [31:0] wdata = '0;
    logic        abort_n = 1'b1;
    logic [31:0] rdata;
    logic        ta_n;
    logic        tea_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_slave_resp #(.DEPTH(DEPTH), .BASE_ADDR(BASE), .WAIT_CYCLES(WAITC)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .tsiz(tsiz),
        .tcode(tcode), .treq_n(treq_n), .tbusy_n(tbusy_n), .wdata(wdata),
        .abort_n(abort_n), .rdata(rdata), .ta_n(ta_n), .tea_n(tea_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // One access; watches 8 cycles after the request edge.
    task automatic access(input logic [31:0] a, input logic rd, input logic [1:0] sz,
                          input logic [31:0] wd, input bit do_abort, input bit busy,
                          output int term_k, output int n_term, output bit err,
                          output logic [31:0] rd_seen, output int n_both);
        term_k = 0; n_term = 0; err = 1'b0; rd_seen = '0; n_both = 0;
        @(negedge clk);
        addr = a; rw = rd; tsiz = sz; wdata = wd; tcode = 3'b101;
        treq_n = 1'b0; tbusy_n = busy ? 1'b0 : 1'b1;
        @(posedge clk);
        @(negedge clk);
        treq_n = 1'b1;
        if (do_abort) abort_n = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            abort_n = 1'b1;
            if (!ta_n && !tea_n) n_both++;
            if (!ta_n || !tea_n) begin
                n_term++;
                if (term_k == 0) begin
                    term_k = k;
                    err = !tea_n;
                    rd_seen = rdata;
                end
            end
        end
        tbusy_n = 1'b1;
    endtask

    task automatic expect_ok(input string tag, input logic [31:0] a, input logic rd,
                             input logic [1:0] sz, input logic [31:0] wd,
                             input logic [31:0] exp_rd);
        int k, n, nb; bit e; logic [31:0] d;
        access(a, rd, sz, wd, 1'b0, 1'b1, k, n, e, d, nb);
        check({tag, " latency R3"}, k, LAT);
        check({tag, " one term R4"}, n, 1);
        check({tag, " no both R4"}, nb, 0);
        check({tag, " ack not err"}, e, 0);
        check({tag, " data"}, d, exp_rd);
    endtask

    task automatic expect_err(input string tag, input logic [31:0] a, input logic rd,
                              input logic [1:0] sz, input logic [31:0] wd);
        int k, n, nb; bit e; logic [31:0] d;
        access(a, rd, sz, wd, 1'b0, 1'b1, k, n, e, d, nb);
        check({tag, " err latency R3"}, k, LAT);
        check({tag, " err flagged"}, e, 1);
        check({tag, " err rdata R13"}, d, 0);
        check({tag, " one term R4"}, n, 1);
    endtask

    task automatic t_reset();
        check("R1 ta_n idle", ta_n, 1);
        check("R1 tea_n idle", tea_n, 1);
        check("R1 rdata idle", rdata, 0);
        expect_ok("R1 cleared word", BASE + 32'h3C, 1'b1, 2'b00, '0, 32'h0);
    endtask

    task automatic t_word();
        expect_ok("R5 R13 word write", BASE + 32'h08, 1'b0, 2'b00, 32'hA1B2C3D4, 32'h0);
        expect_ok("R5 word read", BASE + 32'h08, 1'b1, 2'b00, '0, 32'hA1B2C3D4);
    endtask

    task automatic t_bytes();
        expect_ok("R6 setup", BASE + 32'h10, 1'b0, 2'b00, 32'h11223344, 32'h0);
        expect_ok("R6 byte off0", BASE + 32'h10, 1'b1, 2'b01, '0, 32'h11000000);
        expect_ok("R6 byte off3", BASE + 32'h13, 1'b1, 2'b01, '0, 32'h00000044);
        expect_ok("R7 byte write off1", BASE + 32'h11, 1'b0, 2'b01, 32'hFFEEFFFF, 32'h0);
        expect_ok("R7 word after byte", BASE + 32'h10, 1'b1, 2'b00, '0, 32'h11EE3344);
    endtask

    task automatic t_half();
        expect_ok("R8 half write off2", BASE + 32'h12, 1'b0, 2'b10, 32'hDEAD5566, 32'h0);
        expect_ok("R8 word after half", BASE + 32'h10, 1'b1, 2'b00, '0, 32'h11EE5566);
        expect_ok("R8 half read off0", BASE + 32'h10, 1'b1, 2'b10, '0, 32'h11EE0000);
    endtask

    task automatic t_errors();
        expect_err("R9 reserved size", BASE + 32'h10, 1'b0, 2'b11, 32'h0);
        expect_ok("R9 no write", BASE + 32'h10, 1'b1, 2'b00, '0, 32'h11EE5566);
        expect_err("R10 word misaligned", BASE + 32'h12, 1'b0, 2'b00, 32'h0);
        expect_err("R10 half odd", BASE + 32'h11, 1'b0, 2'b10, 32'h0);
        expect_ok("R10 no write", BASE + 32'h10, 1'b1, 2'b00, '0, 32'h11EE5566);
        expect_err("R11 past top", BASE + 32'(DEPTH * 4), 1'b1, 2'b00, 32'h0);
        expect_err("R11 below base", BASE - 32'h4, 1'b1, 2'b00, 32'h0);
    endtask

    task automatic t_abort();
        int k, n, nb; bit e; logic [31:0] d;
        access(BASE + 32'h10, 1'b0, 2'b00, 32'h0, 1'b1, 1'b1, k, n, e, d, nb);
        check("R12 no term after abort", n, 0);
        expect_ok("R12 no write", BASE + 32'h10, 1'b1, 2'b00, '0, 32'h11EE5566);
    endtask

    task automatic t_nobusy();
        int k, n, nb; bit e; logic [31:0] d;
        access(BASE + 32'h10, 1'b0, 2'b00, 32'h0, 1'b0, 1'b0, k, n, e, d, nb);
        check("R2 ignored without busy", n, 0);
        expect_ok("R2 no write", BASE + 32'h10, 1'b1, 2'b00, '0, 32'h11EE5566);
    endtask

    task automatic t_back2back();
        int k1 = 0, k2 = 0;
        logic [31:0] d2 = '0;
        @(negedge clk);
        addr = BASE + 32'h20; rw = 1'b0; tsiz = 2'b00; wdata = 32'hCAFEF00D;
        treq_n = 1'b0; tbusy_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        treq_n = 1'b1;
        for (int k = 1; k <= 8 && k1 == 0; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (!ta_n) k1 = k;
        end
        check("R14 first latency", k1, LAT);
        addr = BASE + 32'h20; rw = 1'b1; treq_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        treq_n = 1'b1;
        for (int k = 1; k <= 8 && k2 == 0; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (!ta_n) begin k2 = k; d2 = rdata; end
        end
        tbusy_n = 1'b1;
        check("R14 second latency", k2, LAT);
        check("R14 second data", d2, 32'hCAFEF00D);
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word();
        t_bytes();
        t_half();
        t_errors();
        t_abort();
        t_nobusy();
        t_back2back();
        repeat (2) @(posedge clk);
        summary();
    end

endmodule